// File: doc/BRIEF.md
# Bayer Defect Pixel Corrector

This block is a streaming filter for raw Bayer mosaic data. Every accepted pixel is compared with the two pixels of the same color filter on the same line, two positions to its left and two to its right. A pixel stands out as defective when it is brighter than both of those neighbours by more than a programmable threshold, or darker than both by more than that threshold. Such a pixel is replaced by the mean of the two neighbours. No defect list is stored, so any number of defects in a frame is handled.

The block sits in the pixel path right after digitisation. It has a 10-bit pixel bus with a valid strobe and a line-start strobe, an enable bit and a threshold input. The pipeline advances only on valid pixels. A pixel leaves the block at the clock edge that accepts the pixel two valid positions after it. For this reason the last two pixels of a line come out while the first two pixels of the next line are being accepted. Only a short horizontal window is held, and no line memory is used.

Top module: `bayer_defect_fix`

## Requirements
- R1: After reset, `outValid` and `outLineStart` are low and `pixOut` is zero until the first emitted pixel.
- R2: Pixel k of the stream is emitted with `outValid` high for one cycle. This happens in the cycle after the rising edge that accepts pixel k+2, counting only cycles with `pixValid` high. Pixels leave in input order.
- R3: `outLineStart` is high exactly with the emitted pixel that was accepted with `lineStart` high.
- R4: With enable high, a pixel c with same-line neighbours L (position −2) and R (position +2) is replaced when c > L+T and c > R+T. The replacement is floor((L+R)/2), and T is `threshold`.
- R5: With enable high, a pixel is replaced by floor((L+R)/2) when c+T < L and c+T < R.
- R6: A pixel that exceeds or undercuts only one neighbour by more than T, or either neighbour by exactly T or less, leaves unchanged.
- R7: The first two and the last two pixels of every line leave unchanged, whatever their values. A line is ended by the next `lineStart`.
- R8: With `enable` low during the accepting edge of pixel k+2, pixel k leaves unchanged, with the same latency as in R2.
- R9: Idle cycles with `pixValid` low anywhere inside a line change neither the emitted values nor their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | 10 | Raw Bayer pixel |
| pixValid | input | 1 | pixIn holds a pixel this cycle |
| lineStart | input | 1 | Accepted pixel is the first of a line |
| enable | input | 1 | Correction on when high |
| threshold | input | 10 | Defect margin T |
| pixOut | output | 10 | Corrected pixel |
| outValid | output | 1 | pixOut holds a pixel |
| outLineStart | output | 1 | Emitted pixel is the first of its line |

## Verification
The same clock edge can carry the tail of one line out of the block and the start of the next line into it. A pixel near the end of a line that would clearly count as a spike when compared with the new line's pixels must therefore still leave unchanged, while the new line's flag is being taken in. The bench places strong spikes on the last two and first two positions of lines that follow each other directly, and places spikes next to runs of idle cycles. Its scoreboard computes the expected value from the line contents and the line boundary alone, and expects pass-through for those positions and replacement for interior spikes.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // Strobes from the sequencing control to the pixel datapath
  typedef struct packed {
    logic shift;   // a valid pixel is accepted this cycle
    logic emit;    // the pixel two places back leaves this cycle
    logic lsOut;   // that pixel opened its line
    logic nbrOk;   // both same-color neighbours lie in its line
  } dpcStrobe_t;
endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixValid,
  input  logic       lineStart,
  output dpcStrobe_t strobe
);
  localparam int CTR = DEPTH - 3; // index of the centre pixel
  localparam int LFT = DEPTH - 1; // index of the left neighbour

  logic [DEPTH-1:0] filled;
  logic [DEPTH-1:0] startTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filled   <= '0;
      startTag <= '0;
    end else if (pixValid) begin
      filled[0]   <= 1'b1;
      startTag[0] <= lineStart;
    end
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        filled[k]   <= 1'b0;
        startTag[k] <= 1'b0;
      end else if (pixValid) begin
        filled[k]   <= filled[k-1];
        startTag[k] <= startTag[k-1];
      end
    end
  end

  always_comb begin
    strobe.shift = pixValid;
    strobe.emit  = pixValid && filled[CTR];
    strobe.lsOut = startTag[CTR];
    // left neighbour shares the line unless centre or the pixel after it opened one;
    // right neighbour shares it unless the incoming pixel or the one before opened one
    strobe.nbrOk = filled[LFT] && !startTag[CTR] && !startTag[CTR+1]
                   && !startTag[0] && !lineStart;
  end

  p_emit_needs_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> (filled[0] && pixValid));
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpcStrobe_t       strobe,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             enable,
  input  logic [PIX_W-1:0] threshold,
  output logic [PIX_W-1:0] pixOut,
  output logic             outValid,
  output logic             outLineStart
);
  localparam int CTR = DEPTH - 3;
  localparam int LFT = DEPTH - 1;
  localparam int EXT = PIX_W + 1;

  logic [PIX_W-1:0] win [DEPTH];
  logic [PIX_W-1:0] center, leftPx, rightPx, avgPx, loPx, hiPx;
  logic [EXT-1:0]   cE, lE, rE, tE, sumLR;
  logic             isHot, isCold, fixNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) win[0] <= '0;
    else if (strobe.shift) win[0] <= pixIn;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) win[k] <= '0;
      else if (strobe.shift) win[k] <= win[k-1];
    end
  end

  always_comb begin
    center  = win[CTR];
    leftPx  = win[LFT];
    rightPx = pixIn;
    cE      = {1'b0, center};
    lE      = {1'b0, leftPx};
    rE      = {1'b0, rightPx};
    tE      = {1'b0, threshold};
    sumLR   = lE + rE;
    avgPx   = sumLR[EXT-1:1];
    isHot   = (cE > lE + tE) && (cE > rE + tE);
    isCold  = (cE + tE < lE) && (cE + tE < rE);
    fixNow  = enable && strobe.nbrOk && (isHot || isCold);
    loPx    = (leftPx < rightPx) ? leftPx : rightPx;
    hiPx    = (leftPx < rightPx) ? rightPx : leftPx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut       <= '0;
      outValid     <= 1'b0;
      outLineStart <= 1'b0;
    end else begin
      outValid     <= strobe.emit;
      outLineStart <= strobe.emit && strobe.lsOut;
      if (strobe.emit) pixOut <= fixNow ? avgPx : center;
    end
  end

  p_fix_in_span_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.emit && fixNow) |-> (pixOut >= $past(loPx) && pixOut <= $past(hiPx)));
  p_edge_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.emit && !strobe.nbrOk) |-> (pixOut == $past(center)));
  p_off_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.emit && !enable) |-> (pixOut == $past(center)));
endmodule

// File: rtl/bayer_defect_fix.sv
module bayer_defect_fix
  import dpc_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixValid,
  input  logic             lineStart,
  input  logic             enable,
  input  logic [PIX_W-1:0] threshold,
  output logic [PIX_W-1:0] pixOut,
  output logic             outValid,
  output logic             outLineStart
);
  localparam int REACH = 2;             // same-color stride in a Bayer row
  localparam int DEPTH = 2 * REACH;     // held pixels besides the incoming one

  dpcStrobe_t strobe;

  dpc_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart), .strobe(strobe)
  );

  dpc_datapath #(.PIX_W(PIX_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixIn(pixIn), .enable(enable),
    .threshold(threshold), .pixOut(pixOut), .outValid(outValid),
    .outLineStart(outLineStart)
  );

  p_out_follows_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(pixValid));
  p_ls_only_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    outLineStart |-> outValid);
endmodule

// File: tb/test_bayer_defect_fix.sv
module test_bayer_defect_fix;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] pixIn = '0;
  logic       pixValid = 1'b0;
  logic       lineStart = 1'b0;
  logic       enable = 1'b1;
  logic [9:0] threshold = 10'd20;
  logic [9:0] pixOut;
  logic       outValid;
  logic       outLineStart;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  int    linePix [64];
  int    expPixQ [$];
  bit    expLsQ  [$];
  string expTagQ [$];

  always #10 clk = ~clk;

  bayer_defect_fix i_bayer_defect_fix (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .pixValid(pixValid), .lineStart(lineStart),
    .enable(enable), .threshold(threshold), .pixOut(pixOut), .outValid(outValid),
    .outLineStart(outLineStart)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected result for position i of a line of n pixels
  function automatic int model(input int i, input int n, input bit en, input int thr,
                               output string tag);
    int c, l, r;
    c = linePix[i];
    if (i < 2 || i >= n - 2) begin tag = "R7 edge pass"; return c; end
    if (!en) begin tag = "R8 disabled pass"; return c; end
    l = linePix[i-2];
    r = linePix[i+2];
    if (c > l + thr && c > r + thr) begin tag = "R4 hot fix"; return (l + r) / 2; end
    if (c + thr < l && c + thr < r) begin tag = "R5 cold fix"; return (l + r) / 2; end
    tag = "R6 keep";
    return c;
  endfunction

  // Driver: queue the expectations of a line, then present it with optional gaps
  task automatic driveLine(input int n, input bit en, input int thr, input int gap);
    string t;
    for (int i = 0; i < n; i++) begin
      expPixQ.push_back(model(i, n, en, thr, t));
      expLsQ.push_back(i == 0);
      expTagQ.push_back(gap > 0 ? {t, " R9 gaps"} : t);
    end
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i % gap == 1) begin
        @(negedge clk);
        pixValid  = 1'b0;
        lineStart = 1'b0;
        pixIn     = 10'h3ff;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
      pixIn     = linePix[i][9:0];
      pixValid  = 1'b1;
      lineStart = (i == 0);
      enable    = en;
      threshold = thr[9:0];
    end
  endtask

  task automatic flat(input int n, input int v);
    for (int i = 0; i < n; i++) linePix[i] = v;
  endtask

  // Monitor: compare every emitted pixel with the scoreboard head
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expPixQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", pixOut, -1);
      end else begin
        int ep; bit el; string et;
        ep = expPixQ.pop_front();
        el = expLsQ.pop_front();
        et = expTagQ.pop_front();
        check(pixOut == ep, et, pixOut, ep);
        check(outLineStart == el, "R3 line start flag", outLineStart, el);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 reset valid", outValid, 0);
    check(pixOut == 10'd0, "R1 reset pixel", pixOut, 0);
    check(outLineStart == 1'b0, "R1 reset line start", outLineStart, 0);
    rstN = 1'b1;

    // R4/R5: interior spike and dip, odd neighbour sum
    flat(12, 100);
    linePix[5] = 300; linePix[6] = 10;
    linePix[3] = 101; linePix[7] = 200; linePix[9] = 200; linePix[5] = 400;
    driveLine(12, 1'b1, 20, 0);

    // R6: margins at exactly T and T+1, one-sided excess
    flat(14, 100);
    linePix[4] = 120; linePix[7] = 121;
    linePix[8] = 150; linePix[10] = 200;
    driveLine(14, 1'b1, 20, 0);

    // R7: spikes at both edges, next line also starts with spikes
    flat(12, 100);
    linePix[0] = 900; linePix[1] = 5; linePix[10] = 900; linePix[11] = 0;
    driveLine(12, 1'b1, 20, 0);
    flat(12, 100);
    linePix[0] = 1023; linePix[1] = 900; linePix[11] = 800;
    driveLine(12, 1'b1, 20, 0);

    // R8: correction off
    flat(12, 100);
    linePix[5] = 900; linePix[6] = 0;
    driveLine(12, 1'b0, 20, 0);

    // R9: gaps inside the line next to spikes
    flat(16, 500);
    linePix[4] = 1000; linePix[9] = 20; linePix[13] = 999;
    driveLine(16, 1'b1, 30, 3);

    // R7: lines too short for any interior pixel
    flat(3, 50); linePix[1] = 1000;
    driveLine(3, 1'b1, 0, 0);
    flat(4, 60); linePix[2] = 0;
    driveLine(4, 1'b1, 0, 0);

    // mixed random lines, some gapped, some disabled
    for (int L = 0; L < 20; L++) begin
      int n;
      n = $urandom_range(5, 40);
      for (int i = 0; i < n; i++) begin
        linePix[i] = $urandom_range(300, 400);
        if ($urandom_range(0, 5) == 0) linePix[i] = $urandom_range(0, 1023);
      end
      driveLine(n, $urandom_range(0, 4) != 0, $urandom_range(0, 60),
                (L % 3 == 0) ? $urandom_range(2, 4) : 0);
    end

    // trailing line whose last two pixels stay inside the pipe (R2 latency)
    flat(6, 77);
    driveLine(6, 1'b1, 20, 0);
    @(negedge clk);
    pixValid = 1'b0;
    lineStart = 1'b0;
    repeat (10) @(negedge clk);
    check(expPixQ.size() == 2, "R2 two pixels held", expPixQ.size(), 2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule